// File: doc/BRIEF.md
# Asynchronous serial receiver with bus-break detection

This block receives characters from an asynchronous serial line. A free-running 16x oversample tick paces it. A falling edge opens a candidate start bit, which counts only if the line is still low at its mid-point. The data bits that follow are sampled at their centres, least significant first, into an 8-bit byte plus an optional ninth bit. The stop bit is sampled the same way. An optional inversion flips the line polarity before any of this logic sees it, so every symbol, including idle and break, follows the inverted sense.

A separate monitor counts consecutive low tick periods from the start edge and flags a break when the low run reaches a threshold. The threshold is ten bit times, plus one in 9-bit mode and plus one more when long-break mode is on. Long-break mode suits local-interconnect bus slaves, where a 0x00 character stretched by a fast local clock must not be taken for a break. In that mode, received characters never raise the data-full or framing-error flags, and only breaks are reported.

The flags hold until a single read strobe clears them. A receiver-active status sets on each valid start bit. It clears after one character time of continuous idle line.

Top module: `linbrk_rx`

## Requirements
- R1: After reset, data_full, frame_err, overrun, brk_det and rx_active are all 0.
- R2: In 8-bit mode (mode9=0), a character is a low start bit, 8 data bits sent least significant first, and a high stop bit. It loads rx_data and sets data_full, with frame_err=0 and rx_bit8=0.
- R3: In 9-bit mode (mode9=1), nine data bits follow the start bit. The last of them appears on rx_bit8 and the first eight on rx_data[7:0], all loaded together.
- R4: This requirement applies with long_brk=0. If the stop-bit sample is low and the line returns high before the break threshold, the character is loaded with frame_err=1 and data_full=1.
- R5: With long_brk=0, brk_det sets once the line has been low continuously for 10 bit times (mode9=0) or 11 bit times (mode9=1), counted from the start edge. No character is loaded for that low run.
- R6: With long_brk=1, the break threshold is 11 bit times (mode9=0) or 12 bit times (mode9=1). A shorter low run raises no break.
- R7: While long_brk=1, neither data_full nor frame_err sets, whatever characters arrive.
- R8: With rx_inv=1, the pin is inverted before all detection, so an inverted character is received as its true value and a continuous high pin counts as a break.
- R9: While data_full is set, rx_data and rx_bit8 keep their value. A further character is dropped and sets overrun.
- R10: rx_active sets at a valid start bit. It stays set until the line has been idle for one character time (10 bit times, or 11 with mode9=1), then clears.
- R11: A one-cycle pulse on rd clears data_full, frame_err, overrun and brk_det.
- R12: A low pulse shorter than half a bit time is not a start bit: no character is loaded and rx_active stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_pin | input | 1 | Asynchronous serial line |
| mode9 | input | 1 | 1 selects nine data bits |
| long_brk | input | 1 | 1 lengthens the break threshold by one bit and suppresses data flags |
| rx_inv | input | 1 | 1 inverts the line polarity |
| rd | input | 1 | Clears all flags |
| rx_data | output | 8 | Received data byte |
| rx_bit8 | output | 1 | Ninth received bit |
| data_full | output | 1 | A character is held |
| frame_err | output | 1 | Held character had a low stop bit |
| overrun | output | 1 | A character was dropped while full |
| brk_det | output | 1 | Break seen |
| rx_active | output | 1 | Receiver busy with the line |

## Verification
The pin passes two synchronizer flops, and then all timing is counted in ticks from the first tick that sees the line low. Character flags rise one clock after the stop-bit mid-sample, about 9.5 bit times after the start edge in 8-bit mode. A framed character is reported one clock after the line returns high. A break is flagged one clock after the low run reaches its threshold. rx_active falls a full character time after the last high stop sample.

The scoreboard monitor polls the outputs on every falling clock edge and compares the whole flag set in the cycle the first flag appears, so it needs no exact arrival cycle. Low runs are driven a quarter bit below or half a bit above each threshold to stay clear of the one-tick alignment slack. The "nothing happened" checks are taken two bit times after the line has been restored.

// File: rtl/linbrk_rx_pkg.sv
package linbrk_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAITB,
    ST_BRKW
  } rx_state_t;
endpackage

// File: rtl/linbrk_rx_front.sv
module linbrk_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic rx_inv,
  output logic line
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], rx_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  // polarity applied after synchronisation so every symbol follows it
  always_comb begin
    line = sync_q[SYNC_STAGES-1] ^ rx_inv;
  end
endmodule

// File: rtl/linbrk_rx_linemon.sv
module linbrk_rx_linemon #(
  parameter int OSR      = 16,
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic mode9,
  input  logic long_brk,
  output logic brk_hit,
  output logic idle_hit
);
  localparam int MAX_LOW  = (BRK_BITS + 2) * OSR;
  localparam int MAX_HIGH = (DATA_W + 3) * OSR;
  localparam int MAX_ALL  = (MAX_LOW > MAX_HIGH) ? MAX_LOW : MAX_HIGH;
  localparam int CW       = $clog2(MAX_ALL + 1);

  logic [CW-1:0] low_q, low_d;
  logic [CW-1:0] high_q, high_d;
  logic [CW-1:0] thr_ticks;
  logic [CW-1:0] idle_ticks;

  always_comb begin
    thr_ticks  = CW'((BRK_BITS + int'(mode9) + int'(long_brk)) * OSR);
    idle_ticks = CW'((DATA_W + 2 + int'(mode9)) * OSR);
  end

  // consecutive low and high tick runs, each saturating at its limit
  always_comb begin
    low_d    = low_q;
    high_d   = high_q;
    brk_hit  = 1'b0;
    idle_hit = 1'b0;
    if (tick) begin
      if (!line) begin
        high_d = '0;
        if (low_q < thr_ticks) low_d = low_q + CW'(1);
        brk_hit = (low_q == thr_ticks - CW'(1));
      end else begin
        low_d = '0;
        if (high_q < idle_ticks) high_d = high_q + CW'(1);
        idle_hit = (high_q == idle_ticks - CW'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
    end else begin
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  // R5: a break can only be reported while the line is low
  a_r5_break_low_line: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |-> !line);
endmodule

// File: rtl/linbrk_rx_frame.sv
module linbrk_rx_frame
  import linbrk_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line,
  input  logic            mode9,
  input  logic            brk_hit,
  output logic            ev_char,
  output logic            ev_fe,
  output logic            ev_brk,
  output logic            start_ok,
  output logic [DATA_W:0] ev_data
);
  localparam int OW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_W + 2);
  localparam int HALF = OSR / 2;

  rx_state_t        state_q, state_d;
  logic [OW-1:0]    cnt_q, cnt_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [DATA_W:0]  data_q, data_d;
  logic [BW-1:0]    last_bit;

  always_comb begin
    last_bit = BW'(DATA_W - 1) + BW'(mode9);
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    data_d   = data_q;
    ev_char  = 1'b0;
    ev_fe    = 1'b0;
    ev_brk   = 1'b0;
    start_ok = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == OW'(HALF - 2)) begin
            if (!line) begin
              state_d  = ST_DATA;
              cnt_d    = '0;
              bit_d    = '0;
              data_d   = '0;
              start_ok = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + OW'(1);
          end
        end
        ST_DATA: begin
          if (brk_hit) begin
            state_d = ST_BRKW;
            ev_brk  = 1'b1;
          end else if (cnt_q == OW'(OSR - 1)) begin
            data_d[bit_q] = line;
            cnt_d = '0;
            if (bit_q == last_bit) state_d = ST_STOP;
            else                   bit_d   = bit_q + BW'(1);
          end else begin
            cnt_d = cnt_q + OW'(1);
          end
        end
        ST_STOP: begin
          if (brk_hit) begin
            state_d = ST_BRKW;
            ev_brk  = 1'b1;
          end else if (cnt_q == OW'(OSR - 1)) begin
            if (line) begin
              ev_char = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_WAITB;
            end
          end else begin
            cnt_d = cnt_q + OW'(1);
          end
        end
        ST_WAITB: begin
          if (line) begin
            ev_char = 1'b1;
            ev_fe   = 1'b1;
            state_d = ST_IDLE;
          end else if (brk_hit) begin
            ev_brk  = 1'b1;
            state_d = ST_BRKW;
          end
        end
        ST_BRKW: begin
          if (line) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    ev_data = data_q;
  end

  // R2: a character completes only on a high line (stop bit or return to idle)
  a_r2_char_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    ev_char |-> line);
  // R12: a start bit is accepted only while the line is still low
  a_r12_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> !line);
  // R5: a break and a character never complete together
  a_r5_break_or_char: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_char && ev_brk));
endmodule

// File: rtl/linbrk_rx_flags.sv
module linbrk_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_char,
  input  logic              ev_fe,
  input  logic              ev_brk,
  input  logic [DATA_W:0]   ev_data,
  input  logic              start_ok,
  input  logic              idle_hit,
  input  logic              long_brk,
  input  logic              rd,
  output logic [DATA_W-1:0] data_q,
  output logic              bit8_q,
  output logic              full_q,
  output logic              fe_q,
  output logic              ovr_q,
  output logic              brk_q,
  output logic              active_q
);
  logic [DATA_W-1:0] data_d;
  logic              bit8_d, full_d, fe_d, ovr_d, brk_d, active_d;
  logic              accept;

  always_comb begin
    accept   = ev_char && !long_brk;
    data_d   = data_q;
    bit8_d   = bit8_q;
    full_d   = full_q && !rd;
    fe_d     = fe_q && !rd;
    ovr_d    = ovr_q && !rd;
    brk_d    = (brk_q && !rd) || ev_brk;
    active_d = active_q;
    if (accept) begin
      if (full_d) begin
        ovr_d = 1'b1;
      end else begin
        data_d = ev_data[DATA_W-1:0];
        bit8_d = ev_data[DATA_W];
        full_d = 1'b1;
        fe_d   = ev_fe;
      end
    end
    if (idle_hit) active_d = 1'b0;
    if (start_ok) active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      bit8_q   <= 1'b0;
      full_q   <= 1'b0;
      fe_q     <= 1'b0;
      ovr_q    <= 1'b0;
      brk_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      data_q   <= data_d;
      bit8_q   <= bit8_d;
      full_q   <= full_d;
      fe_q     <= fe_d;
      ovr_q    <= ovr_d;
      brk_q    <= brk_d;
      active_q <= active_d;
    end
  end

  // R7: long-break mode keeps data-full and framing error from setting
  a_r7_lin_no_full: assert property (@(posedge clk) disable iff (!rst_n)
    (long_brk && !full_q) |=> !full_q);
  a_r7_lin_no_fe: assert property (@(posedge clk) disable iff (!rst_n)
    (long_brk && !fe_q) |=> !fe_q);
  // R9: held data is never overwritten
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd) |=> ($stable(data_q) && $stable(bit8_q)));
  a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(full_q));
  // R11: a read with no new event leaves every flag clear
  a_r11_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ev_char && !ev_brk) |=> (!full_q && !fe_q && !ovr_q && !brk_q));
  // R10: activity starts only from an accepted start bit
  a_r10_active_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(start_ok));
endmodule

// File: rtl/linbrk_rx.sv
module linbrk_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int BRK_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_pin,
  input  logic              mode9,
  input  logic              long_brk,
  input  logic              rx_inv,
  input  logic              rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              data_full,
  output logic              frame_err,
  output logic              overrun,
  output logic              brk_det,
  output logic              rx_active
);
  logic            line;
  logic            brk_hit, idle_hit;
  logic            ev_char, ev_fe, ev_brk, start_ok;
  logic [DATA_W:0] ev_data;

  linbrk_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_pin (rx_pin),
    .rx_inv (rx_inv),
    .line   (line)
  );

  linbrk_rx_linemon #(.OSR(OSR), .DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .line     (line),
    .mode9    (mode9),
    .long_brk (long_brk),
    .brk_hit  (brk_hit),
    .idle_hit (idle_hit)
  );

  linbrk_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .line     (line),
    .mode9    (mode9),
    .brk_hit  (brk_hit),
    .ev_char  (ev_char),
    .ev_fe    (ev_fe),
    .ev_brk   (ev_brk),
    .start_ok (start_ok),
    .ev_data  (ev_data)
  );

  linbrk_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_char  (ev_char),
    .ev_fe    (ev_fe),
    .ev_brk   (ev_brk),
    .ev_data  (ev_data),
    .start_ok (start_ok),
    .idle_hit (idle_hit),
    .long_brk (long_brk),
    .rd       (rd),
    .data_q   (rx_data),
    .bit8_q   (rx_bit8),
    .full_q   (data_full),
    .fe_q     (frame_err),
    .ovr_q    (overrun),
    .brk_q    (brk_det),
    .active_q (rx_active)
  );
endmodule

// File: tb/linbrk_rx_test.sv
module linbrk_rx_test;
  localparam int BITCLK = 64;  // 16 ticks per bit, tick every 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rx_pin = 1'b1;
  logic       mode9 = 1'b0, long_brk = 1'b0, rx_inv = 1'b0;
  logic       mon_rd = 1'b0, man_rd = 1'b0, rd;
  logic [7:0] rx_data;
  logic       rx_bit8, data_full, frame_err, overrun, brk_det, rx_active;
  logic [1:0] tdiv;

  int n_chk = 0, n_err = 0;
  bit hold_rd = 1'b0;
  bit done = 1'b0;
  logic [10:0] q_item[$];  // {is_break, fe, data9}
  string       q_tag[$];

  always #2.5 clk = ~clk;
  assign rd = mon_rd | man_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign tick = (tdiv == 2'd3);

  linbrk_rx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_pin(rx_pin), .mode9(mode9),
    .long_brk(long_brk), .rx_inv(rx_inv), .rd(rd), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .data_full(data_full), .frame_err(frame_err),
    .overrun(overrun), .brk_det(brk_det), .rx_active(rx_active)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic set_line(input logic lvl);
    rx_pin = lvl ^ rx_inv;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send_char(input logic [8:0] d, input logic stop_hi);
    int nb = mode9 ? 9 : 8;
    set_line(1'b0); wait_bits(1);
    for (int i = 0; i < nb; i++) begin
      set_line(d[i]); wait_bits(1);
    end
    set_line(stop_hi); wait_bits(1);
    set_line(1'b1); wait_bits(2);
  endtask

  task automatic hold_low(input int quarters);
    set_line(1'b0);
    repeat (quarters * 16) @(negedge clk);
    set_line(1'b1);
    wait_bits(2);
  endtask

  task automatic expect_char(input string tag, input logic [8:0] d, input logic fe);
    q_item.push_back({1'b0, fe, d});
    q_tag.push_back(tag);
  endtask

  task automatic expect_break(input string tag);
    q_item.push_back({1'b1, 1'b0, 9'h0});
    q_tag.push_back(tag);
  endtask

  task automatic check_quiet(input string tag);
    check(tag, {data_full, frame_err, brk_det, overrun}, 0);
  endtask

  // monitor: compares each reported result against the scoreboard, then reads
  initial begin
    logic [10:0] it;
    string tg;
    forever begin
      @(negedge clk);
      if (rst_n && !hold_rd && (data_full || brk_det)) begin
        if (q_item.size() == 0) begin
          check("unexpected result", {brk_det, data_full, frame_err, rx_bit8, rx_data}, -1);
        end else begin
          it = q_item.pop_front();
          tg = q_tag.pop_front();
          if (it[10]) check(tg, {brk_det, data_full}, 2'b10);
          else check(tg, {brk_det, data_full, frame_err, rx_bit8, rx_data},
                     {2'b01, it[9], it[8:0]});
        end
        mon_rd = 1'b1;
        @(negedge clk);
        mon_rd = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags after reset",
          {data_full, frame_err, overrun, brk_det, rx_active}, 0);
    wait_bits(2);

    // R12: glitch of three ticks
    set_line(1'b0); repeat (12) @(negedge clk); set_line(1'b1);
    wait_bits(3);
    check("R12 glitch no char", {data_full, frame_err, brk_det}, 0);
    check("R12 glitch not active", rx_active, 0);

    // R2 and R10
    expect_char("R2 char 55", 9'h055, 1'b0);
    fork
      send_char(9'h055, 1'b1);
      begin wait_bits(3); check("R10 active during char", rx_active, 1); end
    join
    check("R10 active shortly after stop", rx_active, 1);
    wait_bits(10);
    check("R10 active clears after idle", rx_active, 0);
    expect_char("R2 char A3", 9'h0A3, 1'b0);
    send_char(9'h0A3, 1'b1);

    // R3
    mode9 = 1'b1; wait_bits(1);
    expect_char("R3 char 1A5", 9'h1A5, 1'b0);
    send_char(9'h1A5, 1'b1);
    expect_char("R3 char 03C", 9'h03C, 1'b0);
    send_char(9'h03C, 1'b1);

    // R4
    mode9 = 1'b0; wait_bits(1);
    expect_char("R4 framing 5A", 9'h05A, 1'b1);
    send_char(9'h05A, 1'b0);
    mode9 = 1'b1; wait_bits(1);
    expect_char("R4 framing 1F0 nine-bit", 9'h1F0, 1'b1);
    send_char(9'h1F0, 1'b0);

    // R5: normal thresholds
    mode9 = 1'b0; wait_bits(1);
    expect_char("R5 low 9.75 bits is framed zero", 9'h000, 1'b1);
    hold_low(39);
    expect_break("R5 low 10.5 bits is break");
    hold_low(42);
    mode9 = 1'b1; wait_bits(1);
    expect_char("R5 nine-bit low 10.75 bits is framed zero", 9'h000, 1'b1);
    hold_low(43);
    expect_break("R5 nine-bit low 11.5 bits is break");
    hold_low(46);

    // R6 and R7: long-break mode
    long_brk = 1'b1; mode9 = 1'b0; wait_bits(1);
    hold_low(43);
    check_quiet("R6 R7 long mode low 10.75 bits quiet");
    expect_break("R6 long mode low 11.5 bits is break");
    hold_low(46);
    mode9 = 1'b1; wait_bits(1);
    hold_low(47);
    check_quiet("R6 R7 long nine-bit low 11.75 bits quiet");
    expect_break("R6 long nine-bit low 12.5 bits is break");
    hold_low(50);
    mode9 = 1'b0; wait_bits(1);
    send_char(9'h05A, 1'b1);
    check_quiet("R7 long mode good char not flagged");
    send_char(9'h05A, 1'b0);
    check_quiet("R7 long mode framed char not flagged");

    // R8: inverted line
    long_brk = 1'b0;
    rx_inv = 1'b1; set_line(1'b1); wait_bits(12);
    expect_char("R8 inverted char C3", 9'h0C3, 1'b0);
    send_char(9'h0C3, 1'b1);
    expect_break("R8 inverted break");
    hold_low(42);
    rx_inv = 1'b0; set_line(1'b1); wait_bits(12);

    // R9 and R11
    hold_rd = 1'b1;
    send_char(9'h011, 1'b1);
    send_char(9'h022, 1'b1);
    check("R9 first char kept", {data_full, rx_data}, {1'b1, 8'h11});
    check("R9 overrun set", overrun, 1);
    @(negedge clk); man_rd = 1'b1; @(negedge clk); man_rd = 1'b0;
    @(negedge clk);
    check("R11 read clears flags", {data_full, frame_err, overrun, brk_det}, 0);
    hold_rd = 1'b0;
    wait_bits(2);

    check("R2 all expected results arrived", q_item.size(), 0);
    finish_run();
  end
endmodule